// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block watches the clock and data lines of an open-drain two-wire serial bus without driving them. It brings both lines into the local clock domain through flop synchronizers. It recognises Start conditions (data falling while clock is high) and Stop conditions (data rising while clock is high), and it keeps a bus-busy flag from one to the other. It also tracks where the current frame stands, counting clock rising edges through eight data bits and an acknowledge slot.

Using that frame position, the monitor flags a Start or Stop that lands in the middle of a byte or in the acknowledge slot. Such an event raises a sticky error and emits a one-cycle release strobe, so that slave logic nearby can drop its addressed state. When the enable input is high, every Start also produces a wake-up strobe for the power controller. For deadlock recovery, the host can force the busy flag clear. A programmable idle counter then reports the bus as free once busy has stayed low for a set number of cycles.

Top module: `twbus_cond_monitor`

## Requirements
- R1: A Start (synchronized data 1→0 while synchronized clock stays 1) or a Stop (data 0→1 while clock stays 1) gives exactly one single-cycle `startPulse` or `stopPulse`. The two strobes never coincide, and clock edges or data changes while the clock is low give neither.
- R2: `busBusy` goes to 1 in the cycle after a Start strobe and returns to 0 in the cycle after a Stop strobe.
- R3: A one-cycle `busyClr` pulse drops `busBusy` to 0 on the next cycle even mid-frame. A Stop seen while busy is already 0 is never treated as illegal.
- R4: When `enable` is 1 during a Start strobe, `wakePulse` is high for exactly one cycle, the cycle after. When `enable` is 0, no wake strobe is produced.
- R5: `bitIndex` is 0 after every Start or Stop. Each clock rising edge adds one. The rising edge after the value 9 gives 1, which starts the next byte. `inAck` is 1 exactly when `bitIndex` is 9.
- R6: A Start or Stop seen while `busBusy` is 1 and `bitIndex` is 2 or more is illegal. It sets `busError` and gives a one-cycle `slaveRelease` strobe. At `bitIndex` 0 or 1 (including a repeated Start just after an acknowledge), the event is legal.
- R7: `busError` stays 1 until the host pulses `errClr`, which clears it on the next cycle.
- R8: `busFree` is 0 while `busBusy` is 1. It rises exactly `idleLimit` cycles after `busBusy` falls, provided busy stays low for that long. With `idleLimit` of 0, it follows `!busBusy`.
- R9: After reset, `busBusy`, `busError`, `bitIndex`, `inAck` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line level |
| sdaIn | input | 1 | Raw bus data line level |
| enable | input | 1 | Allows wake-up strobes on Start |
| busyClr | input | 1 | Host pulse forcing the busy flag clear |
| errClr | input | 1 | Host pulse clearing the sticky error |
| idleLimit | input | 16 | Idle cycles before bus-free is reported |
| startPulse | output | 1 | One-cycle Start strobe |
| stopPulse | output | 1 | One-cycle Stop strobe |
| busBusy | output | 1 | Bus held between Start and Stop |
| bitIndex | output | 4 | Clock rising edges in the current byte (0..9) |
| inAck | output | 1 | Frame is in the acknowledge slot |
| busError | output | 1 | Sticky illegal-condition flag |
| slaveRelease | output | 1 | One-cycle strobe: drop addressed-slave state |
| wakePulse | output | 1 | One-cycle wake-up strobe |
| busFree | output | 1 | Busy has stayed clear for idleLimit cycles |

## Verification
The bench aims at the frame-position boundaries. These include a Stop during the first data bit's clock-high, which is legal, and one a single edge later, which is not. A design off by one in the legality window would flag normal Stops, or miss mid-byte ones. A repeated Start right after the acknowledge slot checks that the count wraps from 9 to 1 rather than to 0 or 10. Stops after a host busy clear must not raise errors. The idle window is measured in exact cycles for both zero and non-zero limits, which exposes a counter that starts one cycle early or late. Wake strobes are tallied with enable both set and cleared.

// File: rtl/tw_mon_pkg.sv
package tw_mon_pkg;

  // line events decoded by the datapath
  typedef struct packed {
    logic startEvt;
    logic stopEvt;
    logic sclRise;
  } lineEvt_t;

  // strobes from control back to the datapath
  typedef struct packed {
    logic frameRst;
    logic idleHold;
  } ctrlCmd_t;

endpackage

// File: rtl/tw_mon_datapath.sv
module tw_mon_datapath
  import tw_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9,
  parameter int IDLE_W      = 16,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctrlCmd_t          cmd,
  input  logic [IDLE_W-1:0] idleLimit,
  output lineEvt_t          evt,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              idleDone
);

  localparam logic [CNT_W-1:0]  LAST_POS = CNT_W'(FRAME_BITS);
  localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic [IDLE_W-1:0] idleCnt;

  // two or more flops per line; idle bus level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // conditions need the clock high on both samples
  always_comb begin
    evt.startEvt = sclNow && sclPrev && sdaPrev && !sdaNow;
    evt.stopEvt  = sclNow && sclPrev && !sdaPrev && sdaNow;
    evt.sclRise  = sclNow && !sclPrev;
  end

  // position inside the frame: data bits then acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (cmd.frameRst) begin
      bitCnt <= '0;
    end else if (evt.sclRise) begin
      bitCnt <= (bitCnt == LAST_POS) ? CNT_W'(1) : bitCnt + 1'b1;
    end
  end

  // saturating idle counter, held at zero while busy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (cmd.idleHold) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign idleDone = (idleCnt >= idleLimit);

endmodule

// File: rtl/tw_mon_ctrl.sv
module tw_mon_ctrl
  import tw_mon_pkg::*;
#(
  parameter int FRAME_BITS = 9,
  localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  lineEvt_t         evt,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             idleDone,
  input  logic             enable,
  input  logic             busyClr,
  input  logic             errClr,
  output ctrlCmd_t         cmd,
  output logic             busBusy,
  output logic             busError,
  output logic             wakePulse,
  output logic             slaveRelease,
  output logic             busFree,
  output logic             inAck
);

  // edges allowed before a condition counts as mid-byte
  localparam int LEGAL_RISES = 1;
  localparam logic [CNT_W-1:0] LEGAL_MAX = CNT_W'(LEGAL_RISES);
  localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(FRAME_BITS);

  logic condSeen;
  logic illegal;

  assign condSeen = evt.startEvt || evt.stopEvt;
  assign illegal  = condSeen && busBusy && (bitCnt > LEGAL_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busBusy <= 1'b0;
    end else if (evt.startEvt) begin
      busBusy <= 1'b1;
    end else if (evt.stopEvt || busyClr) begin
      busBusy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busError <= 1'b0;
    end else if (illegal) begin
      busError <= 1'b1;
    end else if (errClr) begin
      busError <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= evt.startEvt && enable;
    end
  end

  always_comb begin
    cmd.frameRst = condSeen;
    cmd.idleHold = busBusy;
  end

  assign slaveRelease = illegal;
  assign busFree      = !busBusy && idleDone;
  assign inAck        = (bitCnt == ACK_POS);

endmodule

// File: rtl/twbus_cond_monitor.sv
module twbus_cond_monitor
  import tw_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9,
  parameter int IDLE_W      = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              sclIn,
  input  logic                              sdaIn,
  input  logic                              enable,
  input  logic                              busyClr,
  input  logic                              errClr,
  input  logic [IDLE_W-1:0]                 idleLimit,
  output logic                              startPulse,
  output logic                              stopPulse,
  output logic                              busBusy,
  output logic [$clog2(FRAME_BITS+1)-1:0]   bitIndex,
  output logic                              inAck,
  output logic                              busError,
  output logic                              slaveRelease,
  output logic                              wakePulse,
  output logic                              busFree
);

  lineEvt_t evt;
  ctrlCmd_t cmd;
  logic     idleDone;

  tw_mon_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (FRAME_BITS),
    .IDLE_W     (IDLE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .cmd      (cmd),
    .idleLimit(idleLimit),
    .evt      (evt),
    .bitCnt   (bitIndex),
    .idleDone (idleDone)
  );

  tw_mon_ctrl #(
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evt         (evt),
    .bitCnt      (bitIndex),
    .idleDone    (idleDone),
    .enable      (enable),
    .busyClr     (busyClr),
    .errClr      (errClr),
    .cmd         (cmd),
    .busBusy     (busBusy),
    .busError    (busError),
    .wakePulse   (wakePulse),
    .slaveRelease(slaveRelease),
    .busFree     (busFree),
    .inAck       (inAck)
  );

  assign startPulse = evt.startEvt;
  assign stopPulse  = evt.stopEvt;

endmodule

// File: rtl/tw_mon_checker.sv
module tw_mon_checker #(
  parameter int FRAME_BITS = 9,
  parameter int IDLE_W     = 16
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            enable,
  input logic                            busyClr,
  input logic                            errClr,
  input logic [IDLE_W-1:0]               idleLimit,
  input logic                            startPulse,
  input logic                            stopPulse,
  input logic                            busBusy,
  input logic [$clog2(FRAME_BITS+1)-1:0] bitIndex,
  input logic                            busError,
  input logic                            slaveRelease,
  input logic                            wakePulse,
  input logic                            busFree
);

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && stopPulse));

  assert_start_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> busBusy);

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && !startPulse) |=> !busBusy);

  assert_host_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busyClr && !startPulse) |=> !busBusy);

  assert_wake_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && enable) |=> wakePulse);

  assert_wake_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past(startPulse));

  assert_frame_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse || stopPulse) |=> (bitIndex == 0));

  assert_frame_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitIndex <= FRAME_BITS);

  assert_release_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    slaveRelease |=> busError);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busError && !errClr) |=> busError);

  assert_free_not_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busFree |-> !busBusy);

  assert_free_wait_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && idleLimit != 0) |=> !busFree);

endmodule

bind twbus_cond_monitor tw_mon_checker #(
  .FRAME_BITS(FRAME_BITS),
  .IDLE_W    (IDLE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .busyClr     (busyClr),
  .errClr      (errClr),
  .idleLimit   (idleLimit),
  .startPulse  (startPulse),
  .stopPulse   (stopPulse),
  .busBusy     (busBusy),
  .bitIndex    (bitIndex),
  .busError    (busError),
  .slaveRelease(slaveRelease),
  .wakePulse   (wakePulse),
  .busFree     (busFree)
);

// File: tb/twbus_cond_monitor_tb.sv
module twbus_cond_monitor_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclD = 1'b1, sdaD = 1'b1;
  logic enable = 1'b0, busyClr = 1'b0, errClr = 1'b0;
  logic [15:0] idleLimit = 16'd3;
  logic startPulse, stopPulse, busBusy, inAck, busError, slaveRelease, wakePulse, busFree;
  logic [3:0] bitIndex;

  int nChk = 0, nFail = 0;
  int monChk = 0, monFail = 0;
  int expStart = 0, expStop = 0, expWake = 0, expRel = 0;
  int startCnt = 0, stopCnt = 0, wakeCnt = 0, relCnt = 0;
  bit expBusy = 0, expErr = 0;
  int expBit = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twbus_cond_monitor u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclD), .sdaIn(sdaD),
    .enable(enable), .busyClr(busyClr), .errClr(errClr), .idleLimit(idleLimit),
    .startPulse(startPulse), .stopPulse(stopPulse), .busBusy(busBusy),
    .bitIndex(bitIndex), .inAck(inAck), .busError(busError),
    .slaveRelease(slaveRelease), .wakePulse(wakePulse), .busFree(busFree)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: strobe tallies and exact idle window (R8)
  int cyc = 0, fellAt = 0;
  bit armed = 0, busyQ = 0, freeQ = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      armed = 0; busyQ = 0; freeQ = 0;
    end else begin
      startCnt += int'(startPulse);
      stopCnt  += int'(stopPulse);
      wakeCnt  += int'(wakePulse);
      relCnt   += int'(slaveRelease);
      if (busyQ && !busBusy) begin armed = 1; fellAt = cyc; end
      if (busBusy) armed = 0;
      if (busFree && !freeQ && armed) begin
        monChk++;
        if (cyc - fellAt != int'(idleLimit)) begin
          monFail++;
          $display("FAIL R8 idle delay actual=%0d expected=%0d", cyc - fellAt, idleLimit);
        end
        armed = 0;
      end
      if (busFree && busBusy) begin
        monChk++; monFail++;
        $display("FAIL R8 busFree while busy actual=1 expected=0");
      end
      busyQ = busBusy;
      freeQ = busFree;
    end
  end

  task automatic condEvent();
    if (expBusy && expBit >= 2) begin expErr = 1; expRel++; end
    expBit = 0;
  endtask

  // drive one line change, model the expected state, then check it
  task automatic setLines(input logic s, input logic d);
    logic os, od;
    os = sclD; od = sdaD;
    if (os && s && od && !d) begin
      expStart++; if (enable) expWake++;
      condEvent(); expBusy = 1;
    end else if (os && s && !od && d) begin
      expStop++;
      condEvent(); expBusy = 0;
    end else if (!os && s) begin
      expBit = (expBit == 9) ? 1 : expBit + 1;
    end
    @(negedge clk);
    sclD = s; sdaD = d;
    repeat (4) @(negedge clk);
    chk("R2 busBusy", int'(busBusy), int'(expBusy));
    chk("R5 bitIndex", int'(bitIndex), expBit);
    chk("R5 inAck", int'(inAck), int'(expBit == 9));
    chk("R6 busError", int'(busError), int'(expErr));
  endtask

  task automatic sendStart();
    if (!sclD) begin setLines(1'b0, 1'b1); setLines(1'b1, 1'b1); end
    setLines(1'b1, 1'b0);
    setLines(1'b0, 1'b0);
  endtask

  task automatic sendStop();
    if (sclD) setLines(1'b0, sdaD);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
  endtask

  task automatic clockBit(input logic b);
    setLines(1'b0, b);
    setLines(1'b1, b);
    setLines(1'b0, b);
  endtask

  task automatic sendByte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) clockBit(v[i]);
    clockBit(ack);
  endtask

  task automatic clearErr();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
    expErr = 0;
    @(negedge clk);
    chk("R7 error cleared", int'(busError), 0);
  endtask

  task automatic compareCounts(input string tag);
    chk({"R1 start count ", tag}, startCnt, expStart);
    chk({"R1 stop count ", tag}, stopCnt, expStop);
    chk({"R4 wake count ", tag}, wakeCnt, expWake);
    chk({"R6 release count ", tag}, relCnt, expRel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + monChk, nFail + monFail);
      $finish;
    end
  end

  initial begin
    int nb, k;
    bit aborted;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", int'(busBusy), 0);
    chk("R9 error", int'(busError), 0);
    chk("R9 bitIndex", int'(bitIndex), 0);
    chk("R9 strobes", int'(startPulse | stopPulse | wakePulse | slaveRelease), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 inAck", int'(inAck), 0);

    // legal frame with wake enabled (R1 R2 R4 R5)
    enable = 1'b1;
    sendStart();
    sendByte(8'hA5, 1'b0);
    sendStop();
    compareCounts("basic");

    // wake suppressed when disabled (R4)
    enable = 1'b0;
    sendStart();
    sendByte(8'h3C, 1'b0);
    // repeated start just after acknowledge is legal (R6)
    sendStart();
    chk("R6 legal repeated start", int'(busError), 0);
    // stop during the first data bit high is legal (R6)
    setLines(1'b0, 1'b0); setLines(1'b1, 1'b0); setLines(1'b1, 1'b1);
    chk("R6 stop on first bit legal", int'(busError), 0);
    compareCounts("disabled");

    // illegal stop mid-byte, then sticky error (R6 R7)
    enable = 1'b1;
    sendStart();
    clockBit(1'b1); clockBit(1'b0); clockBit(1'b1);
    sendStop();
    repeat (20) @(negedge clk);
    chk("R7 error sticky", int'(busError), 1);
    compareCounts("illegal");
    clearErr();

    // illegal start in acknowledge slot (R6)
    sendStart();
    for (int i = 0; i < 8; i++) clockBit(1'b1);
    setLines(1'b0, 1'b1); setLines(1'b1, 1'b1);
    setLines(1'b1, 1'b0); setLines(1'b0, 1'b0);
    compareCounts("ack start");
    clearErr();
    sendStop();

    // host busy clear mid-frame; later stop is not an error (R3)
    sendStart();
    clockBit(1'b0); clockBit(1'b1); clockBit(1'b1);
    @(negedge clk); busyClr = 1'b1;
    @(negedge clk); busyClr = 1'b0; expBusy = 0;
    @(negedge clk);
    chk("R3 busy cleared", int'(busBusy), 0);
    sendStop();
    chk("R3 no error after clear", int'(busError), 0);

    // idle window, long and zero (R8)
    idleLimit = 16'd25;
    sendStart(); sendByte(8'h81, 1'b0); sendStop();
    repeat (40) @(negedge clk);
    chk("R8 free after long idle", int'(busFree), 1);
    idleLimit = 16'd0;
    @(negedge clk);
    chk("R8 zero limit", int'(busFree), 1);
    sendStart();
    chk("R8 not free while busy", int'(busFree), 0);
    sendStop();
    idleLimit = 16'd3;

    // constrained random frames
    for (int f = 0; f < 50; f++) begin
      @(negedge clk); enable = logic'($urandom % 2);
      if ($urandom % 4 == 0) clearErr();
      sendStart();
      nb = 1 + int'($urandom % 3);
      aborted = 0;
      for (int b = 0; b < nb && !aborted; b++) begin
        if ($urandom % 6 == 0) begin
          k = int'($urandom % 9);
          for (int i = 0; i < k; i++) clockBit(logic'($urandom % 2));
          if ($urandom % 2 == 1) sendStop(); else sendStart();
          aborted = 1;
        end else begin
          sendByte(8'($urandom), logic'($urandom % 2));
        end
      end
      if ($urandom % 3 != 0) begin
        sendStop();
        repeat (int'($urandom % 10)) @(negedge clk);
      end
      compareCounts("random");
    end
    sendStop();
    compareCounts("final");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + monChk, nFail + monFail);
    $finish;
  end

endmodule